// File: doc/BRIEF.md
# Word/Byte Parallel Host Port

This block is the host side of a data converter's parallel bus. A host selects the port with an active-low chip select and then strobes an active-low read or write line. A read places the latest 12-bit conversion result on the data lines. A write loads a 16-bit control register, which the block presents to the rest of the converter. The strobes are sampled on the system clock. Analog pin timing is outside this block.

A mode input chooses the transfer width. With the mode high, all sixteen lines carry a whole word. With the mode low, only the lower eight lines carry data and line 8 becomes an input. Line 8 then picks which half of the register is read or written. The read value follows a coding input. The result is either zero-extended as straight binary or converted to two's complement and sign-extended. The data lines are split into an input vector, an output vector and a per-line output enable, so the pad ring can build the three-state drivers.

Top module: `hp_port`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ctrl_out` is 16'h0000.
- R2: `bus_oe` is nonzero only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. It drops to zero combinationally, in the same cycle that `cs_n` or `rd_n` goes high.
- R3: In word mode (`word_mode`=1), a selected read sets all 16 bits of `bus_oe` and puts the formatted result word on `bus_out`.
- R4: With `bipolar`=0, the formatted word is {4'b0000, result}.
- R5: With `bipolar`=1, `result` is taken as offset binary, where 12'h800 is mid-scale. The formatted word is that value with bit 11 inverted, and bit 11 after inversion is copied into bits 15:12. For example, 12'h3FF gives 16'hFBFF and 12'h800 gives 16'h0000.
- R6: In byte mode (`word_mode`=0), a selected read sets only `bus_oe[7:0]`. `bus_out[7:0]` carries word bits 7:0 when `bus_in[8]`=0 and word bits 15:8 when `bus_in[8]`=1.
- R7: On a clock edge with `cs_n`=0, `wr_n`=0 and `word_mode`=1, the control register loads `bus_in[15:0]`. The new value is visible on `ctrl_out` after that edge.
- R8: On a write edge in byte mode with `bus_in[8]`=0, `ctrl_out[7:0]` loads `bus_in[7:0]` and `ctrl_out[15:8]` is unchanged.
- R9: On a write edge in byte mode with `bus_in[8]`=1, `ctrl_out[15:8]` loads `bus_in[7:0]` and `ctrl_out[7:0]` is unchanged.
- R10: With `cs_n`=1 or `wr_n`=1, the control register keeps its value, whatever `bus_in` holds.
- R11: If `cs_n`, `rd_n` and `wr_n` are all low together, the write takes effect and `bus_oe` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| word_mode | input | 1 | 1: 16-bit transfers; 0: 8-bit transfers with line 8 as half select |
| bipolar | input | 1 | Read coding: 0 straight binary, 1 two's complement |
| result | input | 12 | Latest conversion result, offset binary |
| bus_in | input | 16 | Values seen on the data lines |
| bus_out | output | 16 | Values to drive onto the data lines |
| bus_oe | output | 16 | Per-line output enable |
| ctrl_out | output | 16 | Control register contents |

## Verification
A read and a write can fall in the same cycle when a host lowers both strobes under chip select. The bench provokes this by holding `cs_n`, `rd_n` and `wr_n` low across one clock edge. During that cycle it checks that `bus_oe` stays zero. After the edge it checks that `ctrl_out` shows the written word. A byte write and a byte read can also share line 8's half select, so the bench exercises both halves in each direction. It confirms that the other half of the register is left untouched.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int unsigned HP_BUS_W  = 16;
    localparam int unsigned HP_BYTE_W = 8;
    localparam int unsigned HP_RES_W  = 12;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_LOW  = 2'd2,
        ACC_HIGH = 2'd3
    } acc_t;

    typedef struct packed {
        logic [HP_BUS_W-1:0] ctrl;
    } ctrl_state_t;
endpackage

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
    import hp_pkg::*;
#(
    parameter int unsigned BUS_W  = HP_BUS_W,
    parameter int unsigned BYTE_W = HP_BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_t             acc,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] ctrl_q
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (acc)
            ACC_WORD: st_d.ctrl = din;
            ACC_LOW:  st_d.ctrl[BYTE_W-1:0] = din[BYTE_W-1:0];
            ACC_HIGH: st_d.ctrl[BUS_W-1:BYTE_W] = din[BUS_W-BYTE_W-1:0];
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_IDLE) |=> $stable(ctrl_q)); // R10
    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_WORD) |=> (ctrl_q == $past(din))); // R7
    AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_LOW) |=> ($stable(ctrl_q[BUS_W-1:BYTE_W])
            && ctrl_q[BYTE_W-1:0] == $past(din[BYTE_W-1:0]))); // R8
    AST_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_HIGH) |=> ($stable(ctrl_q[BYTE_W-1:0])
            && ctrl_q[BUS_W-1:BYTE_W] == $past(din[BUS_W-BYTE_W-1:0]))); // R9
endmodule

// File: rtl/hp_read_fmt.sv
module hp_read_fmt
    import hp_pkg::*;
#(
    parameter int unsigned BUS_W  = HP_BUS_W,
    parameter int unsigned BYTE_W = HP_BYTE_W,
    parameter int unsigned RES_W  = HP_RES_W
) (
    input  logic [RES_W-1:0] result,
    input  logic             bipolar,
    input  logic             word_mode,
    input  logic             hi_sel,
    input  logic             rd_sel,
    output logic [BUS_W-1:0] bus_out,
    output logic [BUS_W-1:0] bus_oe
);
    localparam int unsigned EXT_W = BUS_W - RES_W;

    logic [RES_W-1:0] coded;
    logic [BUS_W-1:0] word;

    always_comb begin
        coded = result;
        coded[RES_W-1] = result[RES_W-1] ^ bipolar;
    end

    generate
        if (EXT_W > 0) begin : g_ext
            logic [EXT_W-1:0] fill;
            assign fill = bipolar ? {EXT_W{coded[RES_W-1]}} : '0;
            assign word = {fill, coded};
        end else begin : g_noext
            assign word = coded[BUS_W-1:0];
        end
    endgenerate

    always_comb begin
        bus_out = '0;
        bus_oe  = '0;
        if (word_mode) begin
            bus_out = word;
            if (rd_sel) bus_oe = '1;
        end else begin
            bus_out[BYTE_W-1:0] = hi_sel ? word[BUS_W-1:BYTE_W] : word[BYTE_W-1:0];
            if (rd_sel) bus_oe[BYTE_W-1:0] = '1;
        end
    end

    always_comb begin
        if (!bipolar)
            AST_UNI_ZERO_FILL: assert (word[BUS_W-1:RES_W] == '0); // R4
    end
endmodule

// File: rtl/hp_port.sv
module hp_port
    import hp_pkg::*;
#(
    parameter int unsigned BUS_W  = HP_BUS_W,
    parameter int unsigned BYTE_W = HP_BYTE_W,
    parameter int unsigned RES_W  = HP_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             word_mode,
    input  logic             bipolar,
    input  logic [RES_W-1:0] result,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic [BUS_W-1:0] bus_oe,
    output logic [BUS_W-1:0] ctrl_out
);
    localparam int unsigned HI_LINE = BYTE_W;

    logic wr_sel, rd_sel, hi_sel;
    acc_t acc;

    assign wr_sel = !cs_n && !wr_n;
    assign rd_sel = !cs_n && !rd_n && wr_n;
    assign hi_sel = bus_in[HI_LINE];

    always_comb begin
        if (!wr_sel)        acc = ACC_IDLE;
        else if (word_mode) acc = ACC_WORD;
        else if (hi_sel)    acc = ACC_HIGH;
        else                acc = ACC_LOW;
    end

    hp_ctrl_reg #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .acc(acc), .din(bus_in), .ctrl_q(ctrl_out)
    );

    hp_read_fmt #(.BUS_W(BUS_W), .BYTE_W(BYTE_W), .RES_W(RES_W)) fmt_i (
        .result(result), .bipolar(bipolar), .word_mode(word_mode),
        .hi_sel(hi_sel), .rd_sel(rd_sel), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always_comb begin
        if (bus_oe != '0)
            AST_OE_GATED: assert (!cs_n && !rd_n && wr_n); // R2
        if (!word_mode)
            AST_LINE8_FREE: assert (bus_oe[BUS_W-1:BYTE_W] == '0); // R6
    end

    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !wr_n) |-> (bus_oe == '0)); // R11
endmodule

// File: tb/hp_port_tb_top.sv
module hp_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic word_mode = 1'b1, bipolar = 1'b0;
    logic [11:0] result = '0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out, bus_oe, ctrl_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hp_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .word_mode(word_mode), .bipolar(bipolar), .result(result),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ctrl_out(ctrl_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input bit wmode, input logic [15:0] val);
        @(negedge clk);
        word_mode = wmode; bus_in = val; cs_n = 0; wr_n = 0;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic read_word(input string req, input bit bip, input logic [11:0] r,
                             input bit wmode, input bit hi, input logic [15:0] exp);
        @(negedge clk);
        bipolar = bip; result = r; word_mode = wmode; bus_in = {7'd0, hi, 8'd0};
        cs_n = 0; rd_n = 0;
        #1;
        check(req, bus_oe, wmode ? 16'hFFFF : 16'h00FF);
        if (wmode) check(req, bus_out, exp);
        else       check(req, {8'd0, bus_out[7:0]}, exp);
        cs_n = 1; rd_n = 1;
        #0.5;
        check("R2", bus_oe, 16'h0000);
    endtask

    task automatic t_reset();
        #1; check("R1", ctrl_out, 16'h0000);
        check("R2", bus_oe, 16'h0000);
        @(negedge clk); rst_n = 1;
        @(negedge clk); check("R1", ctrl_out, 16'h0000);
    endtask

    task automatic t_reads();
        read_word("R4", 0, 12'hABC, 1, 0, 16'h0ABC);
        read_word("R5", 1, 12'hABC, 1, 0, 16'h02BC);
        read_word("R5", 1, 12'h3FF, 1, 0, 16'hFBFF);
        read_word("R5", 1, 12'h800, 1, 0, 16'h0000);
        read_word("R3", 0, 12'hFFF, 1, 0, 16'h0FFF);
        read_word("R6", 0, 12'h123, 0, 0, 16'h0023);
        read_word("R6", 0, 12'h123, 0, 1, 16'h0001);
        read_word("R6", 1, 12'h123, 0, 1, 16'h00F9);
    endtask

    task automatic t_rd_release();
        @(negedge clk);
        word_mode = 1; cs_n = 0; rd_n = 0;
        #1; check("R2", bus_oe, 16'hFFFF);
        rd_n = 1; #0.5; check("R2", bus_oe, 16'h0000);
        rd_n = 0; #0.5; check("R2", bus_oe, 16'hFFFF);
        cs_n = 1; #0.5; check("R2", bus_oe, 16'h0000);
        rd_n = 1;
    endtask

    task automatic t_writes();
        do_write(1, 16'hA55A); check("R7", ctrl_out, 16'hA55A);
        do_write(0, 16'hF03C); check("R8", ctrl_out, 16'hA53C);
        do_write(0, 16'h01C3); check("R9", ctrl_out, 16'hC33C);
        @(negedge clk); word_mode = 1; bus_in = 16'hFFFF; cs_n = 1; wr_n = 0;
        @(negedge clk); check("R10", ctrl_out, 16'hC33C);
        wr_n = 1; cs_n = 0;
        @(negedge clk); check("R10", ctrl_out, 16'hC33C);
        cs_n = 1;
    endtask

    task automatic t_collide();
        @(negedge clk);
        word_mode = 1; bus_in = 16'h1234; cs_n = 0; rd_n = 0; wr_n = 0;
        #1; check("R11", bus_oe, 16'h0000);
        @(negedge clk);
        check("R11", ctrl_out, 16'h1234);
        check("R11", bus_oe, 16'h0000);
        cs_n = 1; rd_n = 1; wr_n = 1;
    endtask

    initial begin
        t_reset();
        t_reads();
        t_rd_release();
        t_writes();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule